// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block stores the configuration that a frequency synthesizer's divider chain uses: a 7-bit feedback-divider value M, a 2-bit post-divider code N, and a 3-bit test field. The output frequency the downstream loop produces is the reference times M divided by the post-divide ratio. The step between neighbouring settings is the reference divided by that ratio. The block also decodes the N code into that ratio.

Two load paths write the same divider registers. The parallel path follows the M and N input pins while its strobe is low. It freezes the presented values when the strobe goes high. The serial path works only while that strobe is high. Each rising edge of a serial clock moves one data bit into a 12-bit shift register. A rising edge on a separate serial-load input then copies the shifted word into the test, N and M registers. The shift register and the serial-load input are sampled by the system clock, so each serial-clock level and each load level must last at least one system clock period.

Top module: `synth_div_cfg`

## Requirements
- R1: While `par_load` is low, `m_out` equals `m_in` and `n_out` equals `n_in`, with no clock delay.
- R2: The first system clock edge that samples `par_load` high captures `m_in` and `n_in`. While `par_load` stays high, `m_out` and `n_out` keep those values whatever the inputs do.
- R3: While `par_load` is high, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the 12-bit shift register, and every bit already held moves one place toward bit 11.
- R4: While `par_load` is low, `ser_clk` and `ser_load` have no effect. Neither the shift register nor the test register changes.
- R5: The serial word is sent most significant bit first. Its layout is test field in bits 11:9 (T2 sent first), N code in bits 8:7, and M in bits 6:0.
- R6: A rising edge of `ser_load` while `par_load` is high copies the shift register into `t_out`, `n_out` and `m_out`. Shifting alone never changes the active values.
- R7: `div_ratio` decodes `n_out` as follows: 00 gives 2, 01 gives 4, 10 gives 8, 11 gives 1.
- R8: Reset clears the shift register and the test register and sets M to 25 and N to 00 (ratio 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_load | input | 1 | Parallel strobe: low means transparent, high means hold and enable the serial path |
| m_in | input | 7 | Parallel feedback-divider value |
| n_in | input | 2 | Parallel post-divider code |
| ser_clk | input | 1 | Serial clock, rising edge shifts |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial transfer, rising edge copies the shift register |
| m_out | output | 7 | Active feedback-divider value |
| n_out | output | 2 | Active post-divider code |
| div_ratio | output | 4 | Decoded post-divide ratio (1, 2, 4 or 8) |
| t_out | output | 3 | Test register |

## Verification
The bench sends serial words with a different bit pattern in each field. A design that sends the fields in the wrong order, or shifts toward the wrong end, would place T, N and M bits in the wrong registers. It pulses serial clock and load while the parallel strobe is low, then raises the strobe and transfers again. A design that does not gate the serial path would show the ignored word instead of the earlier one. It transfers right after reset with no shifting. A shift register that reset does not clear would then leave stale bits in M, N and the test field. It also changes the inputs after the strobe rises, which shows whether the parallel path leaks input changes after capture.

// File: rtl/synth_div_cfg_pkg.sv
package synth_div_cfg_pkg;
   localparam int CODE_W  = 2;
   localparam int RATIO_W = 4;

   // Post-divider code to divide ratio: 00->2, 01->4, 10->8, 11->1
   function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
      logic [RATIO_W-1:0] r;
      case (code)
         2'b00:   r = RATIO_W'(2);
         2'b01:   r = RATIO_W'(4);
         2'b10:   r = RATIO_W'(8);
         default: r = RATIO_W'(1);
      endcase
      return r;
   endfunction
endpackage

// File: rtl/cfg_serial_path.sv
module cfg_serial_path #(
   parameter int T_W = 3,
   parameter int N_W = 2,
   parameter int M_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           par_load,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_load,
   output logic           xfer,
   output logic [N_W-1:0] word_n,
   output logic [M_W-1:0] word_m,
   output logic [T_W-1:0] t_out
);
   localparam int SH_W = T_W + N_W + M_W;

   logic            sclk_q, sload_q;
   logic [SH_W-1:0] shreg, shreg_nxt;
   logic [T_W-1:0]  t_q;
   logic            shift_en;

   assign shift_en = par_load && ser_clk && !sclk_q;
   assign xfer     = par_load && ser_load && !sload_q;

   // One stage per bit: bit 0 takes the new data, the rest move up
   for (genvar i = 0; i < SH_W; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign shreg_nxt[i] = ser_data;
      end else begin : g_body
         assign shreg_nxt[i] = shreg[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         sload_q <= 1'b0;
         shreg   <= '0;
         t_q     <= '0;
      end else begin
         sclk_q  <= ser_clk;
         sload_q <= ser_load;
         if (shift_en) shreg <= shreg_nxt;
         if (xfer)     t_q   <= shreg[SH_W-1 -: T_W];
      end
   end

   assign word_n = shreg[M_W +: N_W];
   assign word_m = shreg[M_W-1:0];
   assign t_out  = t_q;

   AST_SER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !par_load |=> ($stable(shreg) && $stable(t_q))); // R4
   AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (par_load && ser_clk && !sclk_q) |=> (shreg[0] == $past(ser_data))); // R3
   AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (par_load && ser_clk && !sclk_q) |=> (shreg[SH_W-1:1] == $past(shreg[SH_W-2:0]))); // R3
endmodule

// File: rtl/cfg_parallel_path.sv
module cfg_parallel_path #(
   parameter int             M_W   = 7,
   parameter int             N_W   = 2,
   parameter logic [M_W-1:0] M_RST = M_W'(25),
   parameter logic [N_W-1:0] N_RST = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           par_load,
   input  logic [M_W-1:0] m_in,
   input  logic [N_W-1:0] n_in,
   input  logic           xfer,
   input  logic [M_W-1:0] ser_m,
   input  logic [N_W-1:0] ser_n,
   output logic [M_W-1:0] m_out,
   output logic [N_W-1:0] n_out
);
   logic           par_q;
   logic [M_W-1:0] m_hold;
   logic [N_W-1:0] n_hold;
   logic           capture;

   // Capture while transparent and on the first edge seen high
   assign capture = !par_load || !par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q  <= 1'b1;
         m_hold <= M_RST;
         n_hold <= N_RST;
      end else begin
         par_q <= par_load;
         if (capture) begin
            m_hold <= m_in;
            n_hold <= n_in;
         end else if (xfer) begin
            m_hold <= ser_m;
            n_hold <= ser_n;
         end
      end
   end

   assign m_out = par_load ? m_hold : m_in;
   assign n_out = par_load ? n_hold : n_in;

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (par_load && par_q && !xfer) |=> ($stable(m_hold) && $stable(n_hold))); // R2
   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (par_load && !par_q) |=> (m_hold == $past(m_in) && n_hold == $past(n_in))); // R2
   AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (par_load && par_q && xfer) |=> (m_hold == $past(ser_m) && n_hold == $past(ser_n))); // R6
endmodule

// File: rtl/cfg_ratio_decode.sv
module cfg_ratio_decode
   import synth_div_cfg_pkg::*;
#(
   parameter int  N_W        = 2,
   parameter int  R_W        = 4,
   parameter bit  USE_LOOKUP = 1'b1
) (
   input  logic [N_W-1:0] code,
   output logic [R_W-1:0] ratio
);
   if (USE_LOOKUP) begin : g_lookup
      assign ratio = R_W'(code_to_ratio(code));
   end else begin : g_shift
      // 00,01,10 -> 1 << (code+1); 11 -> 1
      assign ratio = (code == '1) ? R_W'(1) : R_W'(1) << (code + 1'b1);
   end

   always_comb begin
      AST_RATIO_ONEHOT: assert ($onehot(ratio)); // R7
   end
endmodule

// File: rtl/synth_div_cfg.sv
module synth_div_cfg
   import synth_div_cfg_pkg::*;
#(
   parameter int             M_W   = 7,
   parameter int             N_W   = 2,
   parameter int             T_W   = 3,
   parameter logic [M_W-1:0] M_RST = M_W'(25),
   parameter logic [N_W-1:0] N_RST = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               par_load,
   input  logic [M_W-1:0]     m_in,
   input  logic [N_W-1:0]     n_in,
   input  logic               ser_clk,
   input  logic               ser_data,
   input  logic               ser_load,
   output logic [M_W-1:0]     m_out,
   output logic [N_W-1:0]     n_out,
   output logic [RATIO_W-1:0] div_ratio,
   output logic [T_W-1:0]     t_out
);
   localparam int SH_W = T_W + N_W + M_W;

   if (N_W != CODE_W) begin : g_bad_nw
      $error("synth_div_cfg: N_W must equal the decoder code width");
   end
   if (SH_W != 12) begin : g_bad_sh
      $error("synth_div_cfg: serial word must be 12 bits");
   end

   logic           xfer;
   logic [N_W-1:0] ser_n;
   logic [M_W-1:0] ser_m;

   cfg_serial_path #(.T_W(T_W), .N_W(N_W), .M_W(M_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .par_load(par_load),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
      .xfer(xfer), .word_n(ser_n), .word_m(ser_m), .t_out(t_out)
   );

   cfg_parallel_path #(.M_W(M_W), .N_W(N_W), .M_RST(M_RST), .N_RST(N_RST)) u_par (
      .clk(clk), .rst_n(rst_n), .par_load(par_load),
      .m_in(m_in), .n_in(n_in), .xfer(xfer), .ser_m(ser_m), .ser_n(ser_n),
      .m_out(m_out), .n_out(n_out)
   );

   cfg_ratio_decode #(.N_W(N_W), .R_W(RATIO_W)) u_dec (
      .code(n_out), .ratio(div_ratio)
   );

   AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
      !par_load |-> (m_out == m_in && n_out == n_in)); // R1
   AST_SHIFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (par_load && $past(par_load) && !ser_load) |=> ($stable(m_out) || !par_load)); // R6
endmodule

// File: tb/tb_synth_div_cfg.sv
`timescale 1ns/100ps
module tb_synth_div_cfg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       par_load = 1'b1;
   logic [6:0] m_in = 7'h55;
   logic [1:0] n_in = 2'b11;
   logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
   logic [6:0] m_out;
   logic [1:0] n_out;
   logic [3:0] div_ratio;
   logic [2:0] t_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   synth_div_cfg dut (
      .clk(clk), .rst_n(rst_n), .par_load(par_load), .m_in(m_in), .n_in(n_in),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
      .m_out(m_out), .n_out(n_out), .div_ratio(div_ratio), .t_out(t_out)
   );

   // {m, n, ratio}
   localparam logic [12:0] VEC [6] = '{
      {7'd48,  2'b00, 4'd2},
      {7'd25,  2'b01, 4'd4},
      {7'd56,  2'b10, 4'd8},
      {7'd127, 2'b11, 4'd1},
      {7'd0,   2'b00, 4'd2},
      {7'd85,  2'b11, 4'd1}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_word(input logic [11:0] w);
      for (int i = 11; i >= 0; i--) begin
         ser_data = w[i];
         ser_clk  = 1'b1;
         tick();
         ser_clk  = 1'b0;
         tick();
      end
   endtask

   task automatic pulse_load();
      ser_load = 1'b1;
      tick();
      ser_load = 1'b0;
      tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      // R8: reset values, strobe held high
      repeat (3) tick();
      check("R8 m reset", m_out, 25);
      check("R8 n reset", n_out, 0);
      check("R8 ratio reset", div_ratio, 2);
      check("R8 t reset", t_out, 0);
      rst_n = 1'b1;
      tick();
      // R8: shift register cleared, transfer without shifting gives zeros
      pulse_load();
      check("R8 shreg clear m", m_out, 0);
      check("R8 shreg clear n", n_out, 0);
      check("R8 shreg clear t", t_out, 0);

      // Vector table: R1 transparency, R7 decode, R2 capture and hold
      foreach (VEC[k]) begin
         par_load = 1'b0;
         m_in = VEC[k][12:6];
         n_in = VEC[k][5:4];
         #1;
         check("R1 transparent m", m_out, VEC[k][12:6]);
         check("R1 transparent n", n_out, VEC[k][5:4]);
         check("R7 ratio", div_ratio, VEC[k][3:0]);
         tick();
         par_load = 1'b1;
         tick();
         tick();
         m_in = ~VEC[k][12:6];
         n_in = ~VEC[k][5:4];
         tick();
         check("R2 held m", m_out, VEC[k][12:6]);
         check("R2 held n", n_out, VEC[k][5:4]);
      end

      // R6: shifting alone leaves active values; then transfer. R5 layout
      send_word({3'b101, 2'b10, 7'd100});
      check("R6 shift only m", m_out, 85);
      check("R6 shift only n", n_out, 3);
      check("R6 shift only t", t_out, 0);
      pulse_load();
      check("R5 m field", m_out, 100);
      check("R5 n field", n_out, 2);
      check("R7 ratio after serial", div_ratio, 8);
      check("R5 t field", t_out, 5);

      // R3/R5: asymmetric word catches order and direction errors
      send_word({3'b011, 2'b01, 7'b0000011});
      pulse_load();
      check("R3 t order", t_out, 3);
      check("R3 n order", n_out, 1);
      check("R3 m order", m_out, 3);

      // R4: serial clock and load ignored while strobe low
      par_load = 1'b0;
      m_in = 7'd10;
      n_in = 2'b10;
      tick();
      send_word({3'b110, 2'b11, 7'd77});
      pulse_load();
      check("R4 t unchanged", t_out, 3);
      check("R1 m while low", m_out, 10);
      par_load = 1'b1;
      tick();
      tick();
      check("R2 captured m", m_out, 10);
      pulse_load();
      check("R4 shreg kept m", m_out, 3);
      check("R4 shreg kept n", n_out, 1);
      check("R4 shreg kept t", t_out, 3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule